// File: doc/BRIEF.md
# Serial Bitstream Loader for a Programmable Logic Target

This block writes a configuration image into a downstream programmable device over a three-wire serial load path. On a start pulse it first reads the target's power-sense input. With no supply present it gives up at once and leaves the load pins undriven. With supply present it pulls the active-low clear strobe, releases it, waits a settling time, and then shifts out the requested number of bytes. Each bit is put on the data line while the load clock is low and is captured by the target on the clock's rising edge. After the last bit it samples the target's completion flag, which only rises once the target's own integrity check has passed. The result is reported on three latched flags.

Bytes come from an upstream source over a valid/ready handshake. The byte count is a 32-bit value taken at start. The load clock is divided from the system clock: each high phase and each low phase lasts a programmable number of system clocks. The target's error/init pin is not watched, so an error on the target side never cuts a transfer short.

The controller is one state machine with six named states:
- IDLE: waits for start and clears the result flags when start arrives.
- SENSE: samples power. Power absent goes to IDLE with a no-target failure. Power present goes to CLEAR.
- CLEAR: holds the clear strobe low for the hold count. Count spent goes to SETTLE.
- SETTLE: waits the settle count. Count spent goes to LOAD, or to CHECK when the byte count is zero.
- LOAD: takes and shifts bytes. All bytes taken and the last one fully shifted goes to CHECK.
- CHECK: samples completion, latches pass or fail, and goes to IDLE.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset: busy=0, pins_en=0, prog_n=1, cfg_clk=0, cfg_din=0, s_ready=0, and done_ok, fail and no_target are all 0.
- R2: If tgt_power=0 when sampled after start, the block sets fail=1 and no_target=1, busy returns to 0, and no byte is accepted. While pins_en=0 the block holds prog_n=1, cfg_clk=0 and cfg_din=0; pins_en never rises in this case.
- R3: With tgt_power=1, pins_en rises and prog_n is held low for exactly max(clear_hold,1) consecutive system clocks. prog_n is low only while busy=1.
- R4: At least settle_wait system clocks pass between the release of prog_n and the first rising edge of cfg_clk.
- R5: Bits go out most-significant first. Reading cfg_din at each cfg_clk rising edge gives the accepted bytes in the order accepted, bit 7 through bit 0 of each.
- R6: Every cfg_clk high phase lasts exactly max(phase_div,1) system clocks. Every low phase before a rising edge within a transfer lasts at least max(phase_div,1) system clocks. cfg_din does not change while cfg_clk is high.
- R7: s_ready is high only in LOAD, only after the previous byte's last high phase has ended, and only while accepted bytes are fewer than byte_count. Exactly byte_count bytes are accepted even when more are offered, and s_ready is never high while cfg_clk is high.
- R8: After the last bit, tgt_done is sampled once. A value of 1 gives done_ok=1 and fail=0. A value of 0 gives done_ok=0 and fail=1. In both cases no_target=0 and busy falls.
- R9: A byte_count of 0 produces no cfg_clk pulse and no handshake, and goes straight to the completion check.
- R10: Result flags hold their values while idle until the next start, which clears them. A start pulse while busy=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load; ignored while busy |
| byte_count | input | CNT_W (32) | Number of bytes to send, captured at start |
| phase_div | input | DIV_W | System clocks per load-clock phase (0 treated as 1) |
| clear_hold | input | WAIT_W | System clocks the clear strobe stays low (0 treated as 1) |
| settle_wait | input | WAIT_W | Minimum system clocks from clear release to first clock edge |
| s_valid | input | 1 | Upstream byte valid |
| s_data | input | 8 | Upstream byte |
| s_ready | output | 1 | Byte accepted on a clock edge where s_valid and s_ready are both high |
| tgt_power | input | 1 | Target supply present |
| tgt_done | input | 1 | Target completion flag |
| pins_en | output | 1 | Drive enable for the three load pins |
| prog_n | output | 1 | Active-low configuration clear strobe |
| cfg_clk | output | 1 | Load clock to the target |
| cfg_din | output | 1 | Serial data to the target |
| busy | output | 1 | Sequence in progress |
| done_ok | output | 1 | Latched success |
| fail | output | 1 | Latched failure (completion low or no target) |
| no_target | output | 1 | Latched cause: supply absent at sense |

## Verification
A stuck or skipped state shows up at the pins within one phase time. A wrong wait count changes the measured width of the clear strobe or moves the first clock edge, and both can be seen in the same cycles. A wrong bit counter or shift direction garbles the bits captured at the target and changes how many bytes pass the handshake within one byte time. A bad exit from loading, or a bad capture of the result, shows up as a missing or wrong outcome flag when busy falls. Leaks across runs show up as flags that change while idle, or that survive a new start.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_IDX_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SENSE  = 3'd1,
        ST_CLEAR  = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LOAD   = 3'd4,
        ST_CHECK  = 3'd5
    } cfgl_state_e;

endpackage

// File: rtl/cfgl_phase_timer.sv
// Counts system clocks within one load-clock phase and pulses at its end.
module cfgl_phase_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] ratio,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = (ratio == '0) ? '0 : ratio - DIV_W'(1);
        tick = run && (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // the phase counter never passes the last count (ratio held while running)
    property p_cnt_bound;
        @(posedge clk) disable iff (!rst_n)
        run && $stable(ratio) |-> (cnt <= last);
    endproperty
    assert_cnt_bound_R6: assert property (p_cnt_bound);

endmodule

// File: rtl/cfgl_serializer.sv
// Holds one byte and sends it out MSB first, one clock pulse per bit.
module cfgl_serializer
    import cfgl_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] data,
    input  logic [DIV_W-1:0]  ratio,
    output logic              idle,
    output logic              sclk,
    output logic              sdo
);

    logic                 full;
    logic                 hi;
    logic [BIT_IDX_W-1:0] bitn;
    logic [BYTE_W-1:0]    sh;
    logic                 tick;

    cfgl_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (full),
        .ratio(ratio),
        .tick (tick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            full <= 1'b0;
            hi   <= 1'b0;
            bitn <= '0;
            sh   <= '0;
        end else if (load) begin
            full <= 1'b1;
            hi   <= 1'b0;
            bitn <= '0;
            sh   <= data;
        end else if (full && tick) begin
            if (!hi) begin
                hi <= 1'b1;
            end else if (bitn == BIT_IDX_W'(BYTE_W - 1)) begin
                hi   <= 1'b0;
                full <= 1'b0;
            end else begin
                hi   <= 1'b0;
                bitn <= bitn + BIT_IDX_W'(1);
                sh   <= {sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        idle = !full;
        sclk = full && hi;
        sdo  = sh[BYTE_W-1];
    end

    // data holds steady across a whole high phase
    property p_din_hold;
        @(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(sdo);
    endproperty
    assert_din_hold_R6: assert property (p_din_hold);

    // a new byte is only taken when the previous one has finished
    property p_load_idle;
        @(posedge clk) disable iff (!rst_n)
        load |-> !full;
    endproperty
    assert_load_idle_R7: assert property (p_load_idle);

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfgl_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 32,
    parameter int WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [DIV_W-1:0]  phase_div,
    input  logic [WAIT_W-1:0] clear_hold,
    input  logic [WAIT_W-1:0] settle_wait,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    input  logic              tgt_power,
    input  logic              tgt_done,
    output logic              pins_en,
    output logic              prog_n,
    output logic              cfg_clk,
    output logic              cfg_din,
    output logic              busy,
    output logic              done_ok,
    output logic              fail,
    output logic              no_target
);

    cfgl_state_e       state, state_nx;
    logic [WAIT_W-1:0] wait_cnt;
    logic [CNT_W-1:0]  left;
    logic              take;
    logic              ser_idle;
    logic              ser_clk;
    logic              ser_dout;
    logic              bytes_out;

    assign bytes_out = (left == '0);
    assign take      = s_valid && s_ready;

    cfgl_serializer #(.DIV_W(DIV_W)) u_ser (
        .clk  (clk),
        .rst_n(rst_n),
        .load (take),
        .data (s_data),
        .ratio(phase_div),
        .idle (ser_idle),
        .sclk (ser_clk),
        .sdo  (ser_dout)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_SENSE;
            ST_SENSE:  state_nx = tgt_power ? ST_CLEAR : ST_IDLE;
            ST_CLEAR:  if (wait_cnt <= WAIT_W'(1)) state_nx = ST_SETTLE;
            ST_SETTLE: if (wait_cnt == '0) state_nx = bytes_out ? ST_CHECK : ST_LOAD;
            ST_LOAD:   if (bytes_out && ser_idle) state_nx = ST_CHECK;
            ST_CHECK:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // wait timers, byte counter and latched outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_cnt  <= '0;
            left      <= '0;
            done_ok   <= 1'b0;
            fail      <= 1'b0;
            no_target <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    left      <= byte_count;
                    done_ok   <= 1'b0;
                    fail      <= 1'b0;
                    no_target <= 1'b0;
                end
                ST_SENSE: begin
                    if (tgt_power) begin
                        wait_cnt <= (clear_hold == '0) ? WAIT_W'(1) : clear_hold;
                    end else begin
                        fail      <= 1'b1;
                        no_target <= 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (wait_cnt <= WAIT_W'(1)) wait_cnt <= settle_wait;
                    else                        wait_cnt <= wait_cnt - WAIT_W'(1);
                end
                ST_SETTLE: if (wait_cnt != '0) wait_cnt <= wait_cnt - WAIT_W'(1);
                ST_LOAD:   if (take) left <= left - CNT_W'(1);
                ST_CHECK: begin
                    done_ok <= tgt_done;
                    fail    <= !tgt_done;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        pins_en = (state == ST_CLEAR) || (state == ST_SETTLE) ||
                  (state == ST_LOAD)  || (state == ST_CHECK);
        prog_n  = (state != ST_CLEAR);
        cfg_clk = (state == ST_LOAD) && ser_clk;
        cfg_din = (state == ST_LOAD) && ser_dout;
        s_ready = (state == ST_LOAD) && ser_idle && !bytes_out;
    end

    property p_pins_quiet;
        @(posedge clk) disable iff (!rst_n)
        !pins_en |-> (prog_n && !cfg_clk && !cfg_din);
    endproperty
    assert_pins_quiet_R2: assert property (p_pins_quiet);

    property p_clear_busy;
        @(posedge clk) disable iff (!rst_n)
        !prog_n |-> busy;
    endproperty
    assert_clear_busy_R3: assert property (p_clear_busy);

    property p_ready_clk_low;
        @(posedge clk) disable iff (!rst_n)
        s_ready |-> !cfg_clk;
    endproperty
    assert_ready_clk_low_R7: assert property (p_ready_clk_low);

    property p_outcome_excl;
        @(posedge clk) disable iff (!rst_n)
        $onehot0({done_ok, fail}) && (!no_target || fail);
    endproperty
    assert_outcome_excl_R8: assert property (p_outcome_excl);

    property p_outcome_hold;
        @(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({done_ok, fail, no_target});
    endproperty
    assert_outcome_hold_R10: assert property (p_outcome_hold);

endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] byte_count = '0;
    logic [15:0] phase_div = '0;
    logic [15:0] clear_hold = '0;
    logic [15:0] settle_wait = '0;
    logic        s_valid;
    logic [7:0]  s_data;
    logic        s_ready;
    logic        tgt_power = 1'b0;
    logic        tgt_done = 1'b0;
    logic        pins_en, prog_n, cfg_clk, cfg_din, busy, done_ok, fail, no_target;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    cfg_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .phase_div(phase_div), .clear_hold(clear_hold), .settle_wait(settle_wait),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .tgt_power(tgt_power), .tgt_done(tgt_done), .pins_en(pins_en),
        .prog_n(prog_n), .cfg_clk(cfg_clk), .cfg_din(cfg_din), .busy(busy),
        .done_ok(done_ok), .fail(fail), .no_target(no_target)
    );

    // upstream byte source
    logic [7:0] tx [16];
    int         epoch = 0;
    int         feed_ep = 0;
    int         idx = 0;
    logic       gap_mode = 1'b0;
    logic       gap_t = 1'b0;

    assign s_valid = !gap_mode || gap_t;
    assign s_data  = tx[idx[3:0]];

    always @(posedge clk) begin
        gap_t <= ~gap_t;
        if (feed_ep != epoch) begin
            feed_ep <= epoch;
            idx     <= 0;
        end else if (s_valid && s_ready) begin
            idx <= idx + 1;
        end
    end

    // target-side monitor, sampled on the falling system edge
    int   mon_ep = 0;
    int   cyc = 0;
    int   exp_div = 1;
    logic p_clk = 1'b0, p_prog = 1'b1, p_din = 1'b0;
    logic rx [256];
    int   nbits, prog_run, prog_len, rise_cyc, gap, hi_run, lo_run;
    logic hi_bad, lo_bad, din_bad, pins_seen;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_ep != epoch) begin
            mon_ep = epoch;
            nbits = 0; prog_run = 0; prog_len = 0; rise_cyc = 0; gap = -1;
            hi_run = 0; lo_run = 0;
            hi_bad = 1'b0; lo_bad = 1'b0; din_bad = 1'b0; pins_seen = 1'b0;
        end else begin
            if (pins_en) pins_seen = 1'b1;
            if (!prog_n) prog_run = prog_run + 1;
            if (prog_n && !p_prog) begin
                prog_len = prog_run;
                prog_run = 0;
                rise_cyc = cyc;
            end
            if (cfg_clk && !p_clk) begin
                if (nbits < 256) rx[nbits] = cfg_din;
                if (nbits == 0) gap = cyc - rise_cyc;
                else if (lo_run < exp_div) lo_bad = 1'b1;
                nbits = nbits + 1;
                hi_run = 1;
            end else if (cfg_clk && p_clk) begin
                hi_run = hi_run + 1;
                if (cfg_din != p_din) din_bad = 1'b1;
            end else if (!cfg_clk && p_clk) begin
                if (hi_run != exp_div) hi_bad = 1'b1;
                lo_run = 1;
            end else begin
                lo_run = lo_run + 1;
            end
        end
        p_clk = cfg_clk; p_prog = prog_n; p_din = cfg_din;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (busy && n < 20000) begin
            @(negedge clk);
            n = n + 1;
        end
        if (n >= 20000) chk(1'b0, {req, " timeout"}, n, 0);
    endtask

    task automatic fill_tx(input int seed);
        for (int i = 0; i < 16; i++) tx[i] = 8'((i * 37 + seed * 11 + 8'h5A) ^ (seed << 3));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !pins_en && prog_n && !cfg_clk && !cfg_din && !s_ready,
            "R1 pins at reset", {busy, pins_en, prog_n, cfg_clk, cfg_din, s_ready}, 6'b001000);
        chk(!done_ok && !fail && !no_target, "R1 flags at reset",
            {done_ok, fail, no_target}, 0);
    endtask

    task automatic t_no_power();
        epoch = epoch + 1;
        fill_tx(1);
        tgt_power = 1'b0; byte_count = 4;
        repeat (2) @(negedge clk);
        pulse_start();
        wait_idle("R2");
        chk(fail && no_target && !done_ok, "R2 no-target flags",
            {done_ok, fail, no_target}, 3'b011);
        chk(!pins_seen && nbits == 0 && prog_len == 0, "R2 pins untouched",
            {pins_seen, nbits}, 0);
        chk(idx == 0, "R2 no bytes taken", idx, 0);
    endtask

    task automatic t_load(input int n, input int div, input int clr, input int settle,
                          input logic done_v, input logic gaps, input logic restart, input int seed);
        int bad = 0;
        epoch = epoch + 1;
        fill_tx(seed);
        tgt_power = 1'b1; tgt_done = done_v; gap_mode = gaps;
        byte_count = 32'(n); phase_div = 16'(div); clear_hold = 16'(clr); settle_wait = 16'(settle);
        exp_div = (div == 0) ? 1 : div;
        repeat (2) @(negedge clk);
        pulse_start();
        if (restart) begin
            repeat (40) @(negedge clk);
            chk(busy, "R10 still busy before restart pulse", busy, 1);
            pulse_start();
        end
        wait_idle("R8");
        chk(prog_len == ((clr == 0) ? 1 : clr) && pins_seen, "R3 clear width",
            prog_len, (clr == 0) ? 1 : clr);
        if (n > 0) chk(gap >= settle, "R4 settle before first edge", gap, settle);
        chk(nbits == n * 8, "R5 bit count", nbits, n * 8);
        for (int b = 0; b < n; b++)
            for (int k = 7; k >= 0; k--)
                if (rx[b * 8 + (7 - k)] != tx[b][k]) bad = bad + 1;
        chk(bad == 0, "R5 MSB-first bit order", bad, 0);
        chk(!hi_bad && !lo_bad, "R6 phase widths", {hi_bad, lo_bad}, 0);
        chk(!din_bad, "R6 data stable while high", din_bad, 0);
        chk(idx == n, "R7 bytes accepted", idx, n);
        chk(done_ok == done_v && fail == !done_v && !no_target, "R8 outcome",
            {done_ok, fail, no_target}, {done_v, !done_v, 1'b0});
        if (restart) chk(nbits == n * 8, "R10 restart while busy ignored", nbits, n * 8);
    endtask

    task automatic t_latch();
        logic [2:0] f0;
        f0 = {done_ok, fail, no_target};
        repeat (25) @(negedge clk);
        chk({done_ok, fail, no_target} == f0, "R10 flags hold while idle",
            {done_ok, fail, no_target}, f0);
    endtask

    task automatic t_start_clears();
        epoch = epoch + 1;
        tgt_power = 1'b1; tgt_done = 1'b1; byte_count = 1;
        phase_div = 2; clear_hold = 4; settle_wait = 3; exp_div = 2;
        pulse_start();
        repeat (2) @(negedge clk);
        chk(busy && !fail && !no_target && !done_ok, "R10 start clears flags",
            {busy, done_ok, fail, no_target}, 4'b1000);
        wait_idle("R10");
        chk(done_ok && !fail, "R10 next run outcome", {done_ok, fail}, 2'b10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        fill_tx(0);
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_no_power();                                       // R2
        t_latch();                                          // R10 after fail
        t_load(4, 0, 3, 2, 1'b1, 1'b0, 1'b0, 2);            // R3..R8 pass, divider 0
        t_load(5, 3, 0, 5, 1'b0, 1'b1, 1'b0, 3);            // completion low, gapped source
        t_load(3, 2, 7, 0, 1'b1, 1'b1, 1'b1, 4);            // restart ignored while busy
        t_load(0, 2, 2, 1, 1'b1, 1'b0, 1'b0, 5);            // R9 zero bytes
        chk(nbits == 0 && idx == 0, "R9 no pulses for zero count", nbits, 0);
        t_latch();                                          // R10 after pass
        t_no_power();
        t_start_clears();                                   // R10
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule